// File: doc/BRIEF.md
# Scatter-Gather Region Walker

This block turns one command's data-phase description into a sequence of host memory regions for a DMA back end. A command supplies an address, a length and a mode flag. In direct mode the address is the data buffer and the length is the largest number of bytes to move, so the block hands out exactly one region. In scatter-gather mode the address points at a table in host memory and the length is the table's size in bytes. The block reads the table one 8-byte entry at a time and hands out one region per entry.

Each table entry holds a 4-byte buffer pointer followed by a 4-byte byte count. Both are stored most-significant byte first. The back end reports how many bytes it actually moved for each region. When the walk ends, the block raises a one-cycle completion pulse and reports the residue, which is the number of requested bytes that were not moved.

The controller is a single state machine with these states:
- IDLE: waits for `start`.
- CHECK: validates the table size.
- FETCH: reads the next entry.
- ISSUE: offers a region to the back end.
- MOVE: waits for the moved-byte report.
- DRAIN: reads the remaining entries after an early stop, only to total their lengths.
- FINISH: raises the completion pulse.

Its transitions are:
- IDLE→ISSUE: direct mode with a nonzero length.
- IDLE→FINISH: direct mode with a zero length.
- IDLE→CHECK: scatter-gather mode.
- CHECK→FINISH: the table size is malformed, the entry count is over the limit, or the table is empty.
- CHECK→FETCH: the table is valid and not empty.
- FETCH→ISSUE: the entry has a nonzero length.
- FETCH→FETCH: a zero-length entry that is not the last one.
- FETCH→FINISH: a zero-length last entry.
- ISSUE→MOVE: the back end accepts the region.
- MOVE→FETCH: a full move with more entries left.
- MOVE→DRAIN: a short move with more entries left.
- MOVE→FINISH: the last region, or direct mode.
- DRAIN→FINISH: the last entry has been read.
- FINISH→IDLE: always.

Top module: `sgw_walker`

## Requirements
- R1: After reset, `fetch_req`, `rgn_valid` and `done` are low, and `residue`, `fmt_err` and `limit_err` are zero.
- R2: In direct mode (`sg_mode`=0) with a nonzero `cmd_len`, exactly one region is offered with `rgn_addr`=`cmd_addr` and `rgn_len`=`cmd_len`. The residue is `cmd_len` minus the moved bytes.
- R3: In direct mode with `cmd_len`=0, no region is offered and `done` is high in the cycle right after the clock edge that samples `start`. The residue is 0.
- R4: In scatter-gather mode, entry i is read at `cmd_addr`+8·i in increasing order. The pointer is `fetch_data[63:32]` (table bytes 0..3, big-endian) and the length is `fetch_data[31:0]` (table bytes 4..7). One region per entry is offered in table order.
- R5: An entry whose length is zero produces no region, and the walk continues with the next entry.
- R6: If `cmd_len` is not a multiple of 8 in scatter-gather mode, `fmt_err` is set. No entry is read, no region is offered, the residue is 0, and `done` is high in the second cycle after the edge that samples `start`.
- R7: If `cmd_len`/8 exceeds `max_entries`, `limit_err` is set, with the same empty outcome as R6. A count equal to `max_entries` is accepted.
- R8: When every region is moved in full, the residue is 0 and every entry is read exactly once.
- R9: If `moved_bytes` is less than the region length, no further region is offered. The remaining entries are still read, and the residue equals the unmoved part of that region plus the lengths of all later entries.
- R10: `done` is a one-cycle pulse. `residue`, `fmt_err` and `limit_err` hold their values until the next accepted start.
- R11: `start` while a walk is in progress is ignored. While `fetch_req` waits for `fetch_ack`, its address is held. While `rgn_valid` waits for `rgn_ready`, the region is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; sampled only in IDLE |
| sg_mode | input | 1 | 1 = table walk, 0 = single buffer |
| cmd_addr | input | ADDR_W | Buffer address or table address |
| cmd_len | input | LEN_W | Buffer byte limit or table size in bytes |
| max_entries | input | CNT_W | Largest allowed number of table entries |
| fetch_req | output | 1 | Table entry read request |
| fetch_addr | output | ADDR_W | Address of the requested entry |
| fetch_ack | input | 1 | Entry data valid; completes the read |
| fetch_data | input | ADDR_W+LEN_W | Entry bytes 0..7, byte 0 in the top bits |
| rgn_valid | output | 1 | Region offered to the back end |
| rgn_ready | input | 1 | Back end accepts the region |
| rgn_addr | output | ADDR_W | Region start address |
| rgn_len | output | LEN_W | Region length in bytes |
| moved_valid | input | 1 | Back end reports a finished region |
| moved_bytes | input | LEN_W | Bytes actually moved for that region |
| done | output | 1 | One-cycle completion pulse |
| residue | output | LEN_W | Bytes not transferred |
| fmt_err | output | 1 | Table size not a multiple of 8 |
| limit_err | output | 1 | Table holds more entries than allowed |

## Verification
The only results with a fixed latency are the immediate completions:
- A zero-length direct command: `done` is due one cycle after the edge that samples `start`. The bench drives `start` at a falling edge, so it samples `done` at the very next falling edge.
- A malformed or over-limit table: `done` is due one cycle later than that, because CHECK adds a registered step. The bench therefore samples `done` low at the first falling edge and high at the second.

Everything else waits on handshakes whose timing the bench randomizes. For those walks, the bench polls `done` at falling edges and then compares four things against values computed by its own functions from the table contents:
- the recorded regions,
- the count of entry reads,
- the residue,
- the error flags.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int ENTRY_BYTES = 8;
    localparam int ENTRY_SHIFT = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_ISSUE,
        S_MOVE,
        S_DRAIN,
        S_FINISH
    } walk_state_t;

endpackage

// File: rtl/sgw_table_check.sv
module sgw_table_check #(
    parameter int LEN_W = 32,
    parameter int CNT_W = 8
) (
    input  logic [LEN_W-1:0] tbl_bytes,
    input  logic [CNT_W-1:0] entry_limit,
    output logic [LEN_W-1:0] entry_count,
    output logic             bad_size,
    output logic             over_limit
);
    import sgw_pkg::*;

    localparam int CMP_W = (LEN_W > CNT_W) ? LEN_W : CNT_W;

    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] lim_ext;

    always_comb begin
        entry_count = tbl_bytes >> ENTRY_SHIFT;
        bad_size    = |tbl_bytes[ENTRY_SHIFT-1:0];
        cnt_ext     = CMP_W'(entry_count);
        lim_ext     = CMP_W'(entry_limit);
        over_limit  = cnt_ext > lim_ext;
    end

endmodule

// File: rtl/sgw_desc_unpack.sv
module sgw_desc_unpack #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic [ADDR_W+LEN_W-1:0] raw,
    output logic [ADDR_W-1:0]       ptr,
    output logic [LEN_W-1:0]        len
);
    localparam int NB = (ADDR_W + LEN_W) / 8;
    localparam int PB = ADDR_W / 8;
    localparam int LB = LEN_W / 8;

    logic [7:0] byte_at [NB];

    // Table byte 0 sits in the top bits of the read word.
    for (genvar g = 0; g < NB; g++) begin : g_bytes
        assign byte_at[g] = raw[(NB-1-g)*8 +: 8];
    end

    // Fields are stored most-significant byte first.
    for (genvar j = 0; j < PB; j++) begin : g_ptr
        assign ptr[(PB-1-j)*8 +: 8] = byte_at[j];
    end

    for (genvar j = 0; j < LB; j++) begin : g_len
        assign len[(LB-1-j)*8 +: 8] = byte_at[PB+j];
    end

endmodule

// File: rtl/sgw_residue_acc.sv
module sgw_residue_acc #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_val,
    output logic [LEN_W-1:0] total
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clr) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + add_val;
        end
    end

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    sg_mode,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [CNT_W-1:0]        max_entries,
    output logic                    fetch_req,
    output logic [ADDR_W-1:0]       fetch_addr,
    input  logic                    fetch_ack,
    input  logic [ADDR_W+LEN_W-1:0] fetch_data,
    output logic                    rgn_valid,
    input  logic                    rgn_ready,
    output logic [ADDR_W-1:0]       rgn_addr,
    output logic [LEN_W-1:0]        rgn_len,
    input  logic                    moved_valid,
    input  logic [LEN_W-1:0]        moved_bytes,
    output logic                    done,
    output logic [LEN_W-1:0]        residue,
    output logic                    fmt_err,
    output logic                    limit_err
);
    import sgw_pkg::*;

    walk_state_t st, st_n;

    logic              sg_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  max_q;
    logic [LEN_W-1:0]  nent_q;
    logic [LEN_W-1:0]  idx_q;
    logic [ADDR_W-1:0] rgn_addr_q;
    logic [LEN_W-1:0]  rgn_len_q;
    logic              fmt_q;
    logic              lim_q;

    logic [LEN_W-1:0]  tc_n;
    logic              tc_fmt;
    logic              tc_lim;
    logic [ADDR_W-1:0] dp_ptr;
    logic [LEN_W-1:0]  dp_len;

    logic              last_entry;
    logic              short_move;
    logic [LEN_W-1:0]  unmoved;
    logic              acc_clr;
    logic              acc_en;
    logic [LEN_W-1:0]  acc_val;
    logic              accept;

    sgw_table_check #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_check (
        .tbl_bytes  (len_q),
        .entry_limit(max_q),
        .entry_count(tc_n),
        .bad_size   (tc_fmt),
        .over_limit (tc_lim)
    );

    sgw_desc_unpack #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_unpack (
        .raw(fetch_data),
        .ptr(dp_ptr),
        .len(dp_len)
    );

    sgw_residue_acc #(.LEN_W(LEN_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .add_en (acc_en),
        .add_val(acc_val),
        .total  (residue)
    );

    assign accept     = (st == S_IDLE) && start;
    assign last_entry = (idx_q == nent_q - LEN_W'(1));
    assign short_move = moved_bytes < rgn_len_q;
    assign unmoved    = short_move ? (rgn_len_q - moved_bytes) : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // Next-state decode
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    if (sg_mode)             st_n = S_CHECK;
                    else if (cmd_len == '0)  st_n = S_FINISH;
                    else                     st_n = S_ISSUE;
                end
            end
            S_CHECK: begin
                if (tc_fmt || tc_lim || (tc_n == '0)) st_n = S_FINISH;
                else                                  st_n = S_FETCH;
            end
            S_FETCH: begin
                if (fetch_ack) begin
                    if (dp_len != '0)    st_n = S_ISSUE;
                    else if (last_entry) st_n = S_FINISH;
                    else                 st_n = S_FETCH;
                end
            end
            S_ISSUE: begin
                if (rgn_ready) st_n = S_MOVE;
            end
            S_MOVE: begin
                if (moved_valid) begin
                    if (!sg_q || last_entry) st_n = S_FINISH;
                    else if (short_move)     st_n = S_DRAIN;
                    else                     st_n = S_FETCH;
                end
            end
            S_DRAIN: begin
                if (fetch_ack && last_entry) st_n = S_FINISH;
            end
            S_FINISH: st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    // Walk bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_q       <= 1'b0;
            base_q     <= '0;
            len_q      <= '0;
            max_q      <= '0;
            nent_q     <= '0;
            idx_q      <= '0;
            rgn_addr_q <= '0;
            rgn_len_q  <= '0;
            fmt_q      <= 1'b0;
            lim_q      <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        sg_q       <= sg_mode;
                        base_q     <= cmd_addr;
                        len_q      <= cmd_len;
                        max_q      <= max_entries;
                        nent_q     <= '0;
                        idx_q      <= '0;
                        rgn_addr_q <= cmd_addr;
                        rgn_len_q  <= cmd_len;
                        fmt_q      <= 1'b0;
                        lim_q      <= 1'b0;
                    end
                end
                S_CHECK: begin
                    nent_q <= tc_n;
                    fmt_q  <= tc_fmt;
                    lim_q  <= tc_lim;
                end
                S_FETCH: begin
                    if (fetch_ack) begin
                        rgn_addr_q <= dp_ptr;
                        rgn_len_q  <= dp_len;
                        if ((dp_len == '0) && !last_entry) idx_q <= idx_q + LEN_W'(1);
                    end
                end
                S_MOVE: begin
                    if (moved_valid && sg_q && !last_entry) idx_q <= idx_q + LEN_W'(1);
                end
                S_DRAIN: begin
                    if (fetch_ack && !last_entry) idx_q <= idx_q + LEN_W'(1);
                end
                S_ISSUE, S_FINISH: ;
                default: ;
            endcase
        end
    end

    // Residue accumulation
    always_comb begin
        acc_clr = accept;
        acc_en  = 1'b0;
        acc_val = '0;
        if ((st == S_MOVE) && moved_valid) begin
            acc_en  = 1'b1;
            acc_val = unmoved;
        end else if ((st == S_DRAIN) && fetch_ack) begin
            acc_en  = 1'b1;
            acc_val = dp_len;
        end
    end

    // Outputs
    always_comb begin
        fetch_req  = 1'b0;
        rgn_valid  = 1'b0;
        done       = 1'b0;
        fetch_addr = base_q + (ADDR_W'(idx_q) << ENTRY_SHIFT);
        rgn_addr   = rgn_addr_q;
        rgn_len    = rgn_len_q;
        fmt_err    = fmt_q;
        limit_err  = lim_q;
        unique case (st)
            S_FETCH, S_DRAIN: fetch_req = 1'b1;
            S_ISSUE:          rgn_valid = 1'b1;
            S_FINISH:         done      = 1'b1;
            S_IDLE, S_CHECK, S_MOVE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input sgw_pkg::walk_state_t    st,
    input logic                    start,
    input logic                    sg_mode,
    input logic [LEN_W-1:0]        cmd_len,
    input logic                    fetch_req,
    input logic [ADDR_W-1:0]       fetch_addr,
    input logic                    fetch_ack,
    input logic [ADDR_W+LEN_W-1:0] fetch_data,
    input logic                    rgn_valid,
    input logic                    rgn_ready,
    input logic [ADDR_W-1:0]       rgn_addr,
    input logic [LEN_W-1:0]        rgn_len,
    input logic                    done,
    input logic [LEN_W-1:0]        residue,
    input logic                    fmt_err,
    input logic                    limit_err
);
    import sgw_pkg::*;

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr)); // R11

    AST_RGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rgn_valid && !rgn_ready |=> rgn_valid && $stable(rgn_addr) && $stable(rgn_len)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fmt_err || limit_err) |-> residue == '0); // R6

    AST_ZERO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) && start && !sg_mode && (cmd_len == '0) |=> done); // R3

    AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FETCH) && fetch_ack && (fetch_data[LEN_W-1:0] == '0) |=> !rgn_valid); // R5

endmodule

bind sgw_walker sgw_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .start     (start),
    .sg_mode   (sg_mode),
    .cmd_len   (cmd_len),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .fetch_ack (fetch_ack),
    .fetch_data(fetch_data),
    .rgn_valid (rgn_valid),
    .rgn_ready (rgn_ready),
    .rgn_addr  (rgn_addr),
    .rgn_len   (rgn_len),
    .done      (done),
    .residue   (residue),
    .fmt_err   (fmt_err),
    .limit_err (limit_err)
);

// File: tb/sim_sgw_walker.sv
`timescale 1ns/1ps
module sim_sgw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sg_mode = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_len = '0;
    logic [7:0]  max_entries = '0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic [63:0] fetch_data = '0;
    logic        rgn_valid;
    logic        rgn_ready = 1'b0;
    logic [31:0] rgn_addr;
    logic [31:0] rgn_len;
    logic        moved_valid = 1'b0;
    logic [31:0] moved_bytes = '0;
    logic        done;
    logic [31:0] residue;
    logic        fmt_err;
    logic        limit_err;

    always #2 clk = ~clk;

    sgw_walker u0 (.*);

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] tbl_ptr [16];
    logic [31:0] tbl_len [16];
    logic [31:0] tbl_base;

    logic [31:0] got_addr [32];
    logic [31:0] got_len [32];
    int          got_n;
    int          fetch_n;
    int          stop_idx;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Table memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (fetch_ack) begin
                fetch_ack = 1'b0;
            end else if (fetch_req && ($urandom % 3 != 0)) begin
                automatic int ix = int'((fetch_addr - tbl_base) >> 3);
                fetch_ack  = 1'b1;
                fetch_data = (ix >= 0 && ix < 16) ? {tbl_ptr[ix], tbl_len[ix]} : 64'hdead;
                fetch_n++;
            end
        end
    end

    // Region sink: region number stop_idx moves only half its bytes
    initial begin
        forever begin
            @(negedge clk);
            moved_valid = 1'b0;
            if (rgn_valid && ($urandom % 2 == 1)) begin
                automatic logic [31:0] l = rgn_len;
                rgn_ready = 1'b1;
                if (got_n < 32) begin
                    got_addr[got_n] = rgn_addr;
                    got_len[got_n]  = rgn_len;
                end
                @(negedge clk);
                rgn_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                moved_bytes = (got_n == stop_idx) ? (l >> 1) : l;
                moved_valid = 1'b1;
                got_n++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic issue(input logic sg, input logic [31:0] a, input logic [31:0] l,
                         input logic [7:0] mx, input int stp);
        got_n = 0;
        fetch_n = 0;
        stop_idx = stp;
        tbl_base = a;
        @(negedge clk);
        sg_mode = sg;
        cmd_addr = a;
        cmd_len = l;
        max_entries = mx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Scatter-gather case with expected values computed from the table
    task automatic run_sg(input int nent, input logic [31:0] tlen, input logic [7:0] mx,
                          input int stp, input bit poke);
        logic [31:0] exp_a [32];
        logic [31:0] exp_l [32];
        int exp_n = 0;
        logic [31:0] exp_res = 0;
        bit stopped = 0;
        bit e_fmt = (tlen % 8) != 0;
        bit e_lim = (tlen / 8) > mx;
        int e_fetch = 0;
        bit ok;
        if (!e_fmt && !e_lim) begin
            e_fetch = int'(tlen / 8);
            for (int i = 0; i < int'(tlen / 8); i++) begin
                if (tbl_len[i] == 0) continue;
                if (stopped) begin
                    exp_res += tbl_len[i];
                end else begin
                    exp_a[exp_n] = tbl_ptr[i];
                    exp_l[exp_n] = tbl_len[i];
                    if (exp_n == stp) begin
                        exp_res += tbl_len[i] - (tbl_len[i] >> 1);
                        stopped = (tbl_len[i] >> 1) < tbl_len[i];
                    end
                    exp_n++;
                end
            end
        end
        issue(1'b1, 32'h1000_0000 + 32'($urandom % 64) * 8, tlen, mx, stp);
        if (poke) begin
            repeat (3) @(negedge clk);
            cmd_len = 32'd5;
            sg_mode = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk(ok, "R10 done seen", 32'(ok), 1);
        chk(fmt_err == e_fmt, "R6 fmt_err", 32'(fmt_err), 32'(e_fmt));
        chk(limit_err == e_lim, "R7 limit_err", 32'(limit_err), 32'(e_lim));
        chk(got_n == exp_n, stp >= 0 ? "R9 region count" : "R5 region count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_addr[i] == exp_a[i], "R4 region addr", got_addr[i], exp_a[i]);
            chk(got_len[i] == exp_l[i], "R4 region len", got_len[i], exp_l[i]);
        end
        chk(fetch_n == e_fetch, stp >= 0 ? "R9 entries read" : "R8 entries read", fetch_n, e_fetch);
        chk(residue == exp_res, stp >= 0 ? "R9 residue" : "R8 residue", residue, exp_res);
        @(negedge clk);
        chk(!done, "R10 done pulse", 32'(done), 0);
        chk(residue == exp_res, "R10 residue held", residue, exp_res);
        if (poke) chk(got_n == exp_n, "R11 start ignored while busy", got_n, exp_n);
    endtask

    task automatic run_direct(input logic [31:0] a, input logic [31:0] l, input int stp);
        bit ok;
        logic [31:0] exp_res = (stp == 0) ? l - (l >> 1) : 0;
        issue(1'b0, a, l, 8'd0, stp);
        wait_done(ok);
        chk(ok, "R2 done seen", 32'(ok), 1);
        chk(got_n == 1, "R2 one region", got_n, 1);
        chk(got_addr[0] == a && got_len[0] == l, "R2 region", got_len[0], l);
        chk(residue == exp_res, "R2 residue", residue, exp_res);
        chk(fetch_n == 0, "R2 no entry read", fetch_n, 0);
    endtask

    task automatic fill_random(input int nent);
        for (int i = 0; i < 16; i++) begin
            tbl_ptr[i] = $urandom;
            tbl_len[i] = ($urandom % 4 == 0) ? 32'd0 : 32'($urandom % 4000) + 1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            tbl_ptr[i] = '0;
            tbl_len[i] = '0;
        end
        tbl_base = '0;
        got_n = 0;
        fetch_n = 0;
        stop_idx = -1;
        repeat (3) @(negedge clk);
        chk(!fetch_req && !rgn_valid && !done, "R1 idle outputs", {fetch_req, rgn_valid, done}, 0);
        chk(residue == 0 && !fmt_err && !limit_err, "R1 reset status", residue, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: zero-length direct, done exactly one cycle after start
        got_n = 0;
        sg_mode = 1'b0; cmd_len = 0; cmd_addr = 32'h40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done, "R3 done timing", 32'(done), 1);
        chk(residue == 0, "R3 residue", residue, 0);
        chk(got_n == 0, "R3 no region", got_n, 0);

        // R6: malformed table size, done at second cycle
        issue(1'b1, 32'h2000, 32'd20, 8'd8, -1);
        chk(!done, "R6 done not early", 32'(done), 0);
        @(negedge clk);
        chk(done && fmt_err, "R6 done timing", {done, fmt_err}, 2'b11);
        chk(residue == 0 && fetch_n == 0 && got_n == 0, "R6 empty", residue, 0);

        // R2: direct modes
        run_direct(32'h0000_8000, 32'd512, -1);
        run_direct(32'h0001_0004, 32'd301, 0);

        // Directed table cases
        fill_random(16);
        run_sg(6, 32'd48, 8'd4, -1, 0);     // R7 over limit
        run_sg(4, 32'd32, 8'd4, -1, 0);     // R7 exactly at limit
        for (int i = 0; i < 16; i++) tbl_len[i] = 0;
        run_sg(5, 32'd40, 8'd8, -1, 0);     // R5 all zero entries
        fill_random(16);
        tbl_len[0] = 32'd100;
        run_sg(8, 32'd64, 8'd8, 0, 0);      // R9 stop at first region
        run_sg(7, 32'd56, 8'd8, -1, 1);     // R11 start poked mid-walk

        // Random walks
        for (int c = 0; c < 30; c++) begin
            automatic int ne = $urandom % 13;
            automatic int sp = ($urandom % 2 == 0) ? -1 : int'($urandom % 13);
            fill_random(16);
            run_sg(ne, 32'(ne * 8), 8'd12, sp, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule